// File: doc/BRIEF.md
# Signed-Digit Adder/Subtractor

This block adds or subtracts two integers in radix-2 balanced signed-digit form. Every digit is one of -1, 0 or +1. Each operand is carried on two bit vectors: a plus vector and a minus vector. The operand's value is the plus vector minus the minus vector, read as unsigned integers. Because a number needs both vectors, it takes twice the storage of a two's complement word with the same range. In return, addition needs no carry chain across the word. Each result digit depends on a small fixed window of operand positions, so the delay stays the same as the word grows.

Subtraction never forms a two's complement. It swaps the plus and minus vectors of the second operand and then adds. A caller pulses `start_i` with the operands and the operation select. The result is registered and `valid_o` flags it one cycle later. The result has one more digit than the operands, so the top transfer is never dropped. A separate output gives the result's value as a two's complement number, so checking can compare it against plain integer arithmetic. To encode an ordinary unsigned binary number, put it on the plus vector and leave the minus vector zero.

Top module: `sdigit_addsub`

## Requirements
- R1: With `sub_i` low, the result value equals A + B. The value of a digit vector pair is the sum over positions i of (plus[i] - minus[i]) * 2^i.
- R2: With `sub_i` high, the result value equals A - B.
- R3: An operand position with both its plus and minus bits set is worth 0. The result is the same as if both bits were clear.
- R4: No result position ever has both its plus and minus bits set.
- R5: `valid_o` is high in exactly the cycle after a cycle with `start_i` high, and low otherwise.
- R6: The result registers load only on a cycle with `start_i` high. Otherwise they hold, whatever the operand inputs do.
- R7: The result has N+1 digits. The extreme values +(2^(N+1)-2) and -(2^(N+1)-2) are produced without loss.
- R8: `res_val_o` equals the value of the registered result, as an (N+2)-bit two's complement number.
- R9: While `rst_ni` is low, `valid_o` is 0 and every result bit is 0.
- R10: Changing operand digits at position k or above leaves result digits below k unchanged. No carry propagates across the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operands valid; load the result |
| sub_i | input | 1 | 1: A - B, 0: A + B |
| a_pos_i | input | N_DIGITS | Plus vector of A |
| a_neg_i | input | N_DIGITS | Minus vector of A |
| b_pos_i | input | N_DIGITS | Plus vector of B |
| b_neg_i | input | N_DIGITS | Minus vector of B |
| valid_o | output | 1 | Result valid, one cycle after start |
| res_pos_o | output | N_DIGITS+1 | Plus vector of the result |
| res_neg_o | output | N_DIGITS+1 | Minus vector of the result |
| res_val_o | output | N_DIGITS+2 | Two's complement value of the result |

## Verification
The assertions check on every cycle:
- the valid timing;
- that the result holds when no start arrives;
- that no result digit is ever encoded with both bits set;
- that the value presented after each start matches the sum or difference of the operands.

Only the bench's scenarios can show the following:
- that both-set operand positions count as zero;
- that the extreme operands reach the widest result value;
- that changing high operand digits leaves the low result digits untouched, which is the carry-free locality;
- the reset state;
- that the debug value agrees with a digit-by-digit reading of the result vectors.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef struct packed {
    logic p;
    logic n;
  } sd_digit_t;

  function automatic logic signed [2:0] dval(input logic p, input logic n);
    return $signed({2'b00, p}) - $signed({2'b00, n});
  endfunction

  // sum of two digits known to land in -1..1
  function automatic sd_digit_t add_digits(input sd_digit_t x, input sd_digit_t y);
    logic signed [2:0] v;
    sd_digit_t r;
    v = dval(x.p, x.n) + dval(y.p, y.n);
    r.p = (v == 3'sd1);
    r.n = (v == -3'sd1);
    return r;
  endfunction
endpackage

// File: rtl/sd_transfer_slice.sv
module sd_transfer_slice
  import sd_pkg::*;
(
  input  logic      a_p_i,
  input  logic      a_n_i,
  input  logic      b_p_i,
  input  logic      b_n_i,
  input  logic      low_nonneg_i,
  output logic      nonneg_o,
  output sd_digit_t xfer_o,
  output sd_digit_t interim_o
);
  logic signed [2:0] s;

  always_comb begin
    s = dval(a_p_i, a_n_i) + dval(b_p_i, b_n_i);
    xfer_o    = '0;
    interim_o = '0;
    unique case (s)
      3'b010: xfer_o.p = 1'b1;
      3'b110: xfer_o.n = 1'b1;
      // +1: take the transfer only if the lower position cannot send -1
      3'b001: begin
        if (low_nonneg_i) begin
          xfer_o.p    = 1'b1;
          interim_o.n = 1'b1;
        end else begin
          interim_o.p = 1'b1;
        end
      end
      3'b111: begin
        if (low_nonneg_i) begin
          interim_o.n = 1'b1;
        end else begin
          xfer_o.n    = 1'b1;
          interim_o.p = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign nonneg_o = ~s[2];
endmodule

// File: rtl/sd_adder_array.sv
module sd_adder_array
  import sd_pkg::*;
#(
  parameter int N_DIGITS = 16
) (
  input  logic [N_DIGITS-1:0] a_pos_i,
  input  logic [N_DIGITS-1:0] a_neg_i,
  input  logic [N_DIGITS-1:0] b_pos_i,
  input  logic [N_DIGITS-1:0] b_neg_i,
  output logic [N_DIGITS:0]   z_pos_o,
  output logic [N_DIGITS:0]   z_neg_o
);
  logic [N_DIGITS:0] nonneg;
  sd_digit_t         xfer    [N_DIGITS];
  sd_digit_t         interim [N_DIGITS];
  sd_digit_t         z       [N_DIGITS+1];

  assign nonneg[0] = 1'b1;

  for (genvar i = 0; i < N_DIGITS; i++) begin : g_slice
    sd_transfer_slice u_slice (
      .a_p_i        (a_pos_i[i]),
      .a_n_i        (a_neg_i[i]),
      .b_p_i        (b_pos_i[i]),
      .b_n_i        (b_neg_i[i]),
      .low_nonneg_i (nonneg[i]),
      .nonneg_o     (nonneg[i+1]),
      .xfer_o       (xfer[i]),
      .interim_o    (interim[i])
    );
  end

  for (genvar i = 0; i <= N_DIGITS; i++) begin : g_combine
    if (i == 0) begin : g_lsd
      assign z[i] = interim[i];
    end else if (i == N_DIGITS) begin : g_msd
      assign z[i] = xfer[i-1];
    end else begin : g_mid
      assign z[i] = add_digits(interim[i], xfer[i-1]);
    end
    assign z_pos_o[i] = z[i].p;
    assign z_neg_o[i] = z[i].n;
  end
endmodule

// File: rtl/sd_value_conv.sv
module sd_value_conv #(
  parameter int N_POS = 17,
  localparam int VAL_W = N_POS + 1
) (
  input  logic [N_POS-1:0] pos_i,
  input  logic [N_POS-1:0] neg_i,
  output logic [VAL_W-1:0] val_o
);
  assign val_o = {1'b0, pos_i} - {1'b0, neg_i};
endmodule

// File: rtl/sdigit_addsub.sv
module sdigit_addsub #(
  parameter int N_DIGITS = 16,
  localparam int RES_W = N_DIGITS + 1,
  localparam int VAL_W = N_DIGITS + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                sub_i,
  input  logic [N_DIGITS-1:0] a_pos_i,
  input  logic [N_DIGITS-1:0] a_neg_i,
  input  logic [N_DIGITS-1:0] b_pos_i,
  input  logic [N_DIGITS-1:0] b_neg_i,
  output logic                valid_o,
  output logic [RES_W-1:0]    res_pos_o,
  output logic [RES_W-1:0]    res_neg_o,
  output logic [VAL_W-1:0]    res_val_o
);
  logic [N_DIGITS-1:0] b_pos_eff, b_neg_eff;
  logic [RES_W-1:0]    sum_pos, sum_neg;

  // negation of a signed-digit number is a vector swap
  assign b_pos_eff = sub_i ? b_neg_i : b_pos_i;
  assign b_neg_eff = sub_i ? b_pos_i : b_neg_i;

  sd_adder_array #(.N_DIGITS(N_DIGITS)) u_array (
    .a_pos_i (a_pos_i),
    .a_neg_i (a_neg_i),
    .b_pos_i (b_pos_eff),
    .b_neg_i (b_neg_eff),
    .z_pos_o (sum_pos),
    .z_neg_o (sum_neg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      res_pos_o <= '0;
      res_neg_o <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        res_pos_o <= sum_pos;
        res_neg_o <= sum_neg;
      end
    end
  end

  sd_value_conv #(.N_POS(RES_W)) u_conv (
    .pos_i (res_pos_o),
    .neg_i (res_neg_o),
    .val_o (res_val_o)
  );
endmodule

// File: rtl/sdigit_addsub_chk.sv
module sdigit_addsub_chk #(
  parameter int N_DIGITS = 16,
  localparam int RES_W = N_DIGITS + 1,
  localparam int VAL_W = N_DIGITS + 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                sub_i,
  input logic [N_DIGITS-1:0] a_pos_i,
  input logic [N_DIGITS-1:0] a_neg_i,
  input logic [N_DIGITS-1:0] b_pos_i,
  input logic [N_DIGITS-1:0] b_neg_i,
  input logic                valid_o,
  input logic [RES_W-1:0]    res_pos_o,
  input logic [RES_W-1:0]    res_neg_o,
  input logic [VAL_W-1:0]    res_val_o
);
  logic signed [VAL_W-1:0] a_v, b_v, exp_add, exp_sub;

  assign a_v     = $signed({2'b00, a_pos_i}) - $signed({2'b00, a_neg_i});
  assign b_v     = $signed({2'b00, b_pos_i}) - $signed({2'b00, b_neg_i});
  assign exp_add = a_v + b_v;
  assign exp_sub = a_v - b_v;

  AST_VALID_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni) start_i |=> valid_o); // R5
  AST_NO_VALID_WITHOUT_START: assert property (@(posedge clk_i) disable iff (!rst_ni) !start_i |=> !valid_o); // R5
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni) !start_i |=> ($stable(res_pos_o) && $stable(res_neg_o))); // R6
  AST_CANONICAL_DIGITS: assert property (@(posedge clk_i) disable iff (!rst_ni) (res_pos_o & res_neg_o) == '0); // R4
  AST_ADD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni) (start_i && !sub_i) |=> $signed(res_val_o) == $past(exp_add)); // R1
  AST_SUB_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni) (start_i && sub_i) |=> $signed(res_val_o) == $past(exp_sub)); // R2
endmodule

bind sdigit_addsub sdigit_addsub_chk #(.N_DIGITS(N_DIGITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .sub_i     (sub_i),
  .a_pos_i   (a_pos_i),
  .a_neg_i   (a_neg_i),
  .b_pos_i   (b_pos_i),
  .b_neg_i   (b_neg_i),
  .valid_o   (valid_o),
  .res_pos_o (res_pos_o),
  .res_neg_o (res_neg_o),
  .res_val_o (res_val_o)
);

// File: tb/sdigit_addsub_tb_top.sv
module sdigit_addsub_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, sub;
  logic [W-1:0] ap, an, bp, bn;
  logic         valid;
  logic [W:0]   rp, rn;
  logic [W+1:0] rv;
  int           n_chk = 0;
  int           n_bad = 0;

  always #2 clk = ~clk;

  sdigit_addsub #(.N_DIGITS(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sub_i(sub),
    .a_pos_i(ap), .a_neg_i(an), .b_pos_i(bp), .b_neg_i(bn),
    .valid_o(valid), .res_pos_o(rp), .res_neg_o(rn), .res_val_o(rv)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint val_of(input logic [W:0] p, input logic [W:0] n);
    longint v = 0;
    for (int i = 0; i <= W; i++) v += (longint'(p[i]) - longint'(n[i])) * (longint'(1) << i);
    return v;
  endfunction

  function automatic longint opval(input logic [W-1:0] p, input logic [W-1:0] n);
    return val_of({1'b0, p}, {1'b0, n});
  endfunction

  task automatic run_op(input logic [W-1:0] a_p, input logic [W-1:0] a_n,
                        input logic [W-1:0] b_p, input logic [W-1:0] b_n,
                        input bit s, input string req);
    longint exp;
    @(negedge clk);
    ap = a_p; an = a_n; bp = b_p; bn = b_n; sub = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp = s ? opval(a_p, a_n) - opval(b_p, b_n) : opval(a_p, a_n) + opval(b_p, b_n);
    chk(valid === 1'b1, "R5", longint'(valid), 1);
    chk(val_of(rp, rn) == exp, req, val_of(rp, rn), exp);
    chk((rp & rn) == '0, "R4", longint'(rp & rn), 0);
    chk(longint'($signed(rv)) == val_of(rp, rn), "R8", longint'($signed(rv)), val_of(rp, rn));
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start = 1'b0; sub = 1'b0; ap = '0; an = '0; bp = '0; bn = '0;
    repeat (3) @(negedge clk);
    chk(valid === 1'b0, "R9 valid", longint'(valid), 0);
    chk(rp === '0 && rn === '0, "R9 result", longint'(rp | rn), 0);
    chk(rv === '0, "R9 value", longint'(rv), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_add_plain();
    run_op(16'd1234, '0, 16'd4321, '0, 1'b0, "R1 plain");
    run_op(16'hFFFF, '0, 16'd1, '0, 1'b0, "R1 wrap");
    run_op(16'h5555, '0, 16'hAAAA, '0, 1'b0, "R1 alt");
  endtask

  task automatic test_sub();
    run_op(16'd100, '0, 16'd300, '0, 1'b1, "R2 negative");
    run_op(16'hFF00, 16'h00F0, 16'h0F0F, 16'h3000, 1'b1, "R2 mixed");
    run_op('0, '0, 16'h8001, 16'h0110, 1'b1, "R2 negate");
  endtask

  task automatic test_both_bits();
    // all positions of A both-set: A is worth 0, so the result equals B
    run_op(16'hFFFF, 16'hFFFF, 16'h1234, 16'h0042, 1'b0, "R3 zero A");
    chk(val_of(rp, rn) == opval(16'h1234, 16'h0042), "R3 equals B",
        val_of(rp, rn), opval(16'h1234, 16'h0042));
    run_op(16'h0F0F, 16'h0F00, 16'h00FF, 16'h00F0, 1'b1, "R3 partial");
  endtask

  task automatic test_extremes();
    longint mx = (longint'(1) << (W + 1)) - 2;
    run_op(16'hFFFF, '0, 16'hFFFF, '0, 1'b0, "R7 max");
    chk(val_of(rp, rn) == mx, "R7 max value", val_of(rp, rn), mx);
    run_op('0, 16'hFFFF, '0, 16'hFFFF, 1'b0, "R7 min");
    chk(val_of(rp, rn) == -mx, "R7 min value", val_of(rp, rn), -mx);
    run_op(16'hFFFF, '0, '0, 16'hFFFF, 1'b1, "R7 sub max");
    chk(rp[W] | rn[W], "R7 top digit used", longint'(rp[W] | rn[W]), 1);
  endtask

  task automatic test_hold();
    logic [W:0] hp, hn;
    run_op(16'd77, '0, 16'd5, '0, 1'b0, "R1 before hold");
    hp = rp; hn = rn;
    @(negedge clk);
    ap = 16'hFFFF; bp = 16'h1111; sub = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(valid === 1'b0, "R5 idle", longint'(valid), 0);
      chk(rp === hp && rn === hn, "R6 hold", val_of(rp, rn), val_of(hp, hn));
    end
  endtask

  task automatic test_locality();
    logic [W:0] lp, ln;
    localparam int K = 8;
    run_op(16'h3C5A, 16'h0081, 16'h1F0F, 16'h2200, 1'b0, "R1 base");
    lp = rp; ln = rn;
    run_op(16'hC35A, 16'hA081, 16'h1F0F, 16'h2200, 1'b0, "R1 high change");
    chk(rp[K-1:0] === lp[K-1:0] && rn[K-1:0] === ln[K-1:0], "R10 low digits",
        longint'({rp[K-1:0], rn[K-1:0]}), longint'({lp[K-1:0], ln[K-1:0]}));
  endtask

  task automatic test_random();
    for (int i = 0; i < 40; i++) begin
      run_op(W'($urandom), W'($urandom), W'($urandom), W'($urandom), 1'($urandom),
             "R1/R2 random");
    end
  endtask

  initial begin
    test_reset();
    test_add_plain();
    test_sub();
    test_both_bits();
    test_extremes();
    test_hold();
    test_locality();
    test_random();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule